// File: doc/BRIEF.md
# Reset Pin Sequencer

This block runs the reset sequence of a small controller from the E clock. It watches three internal reset sources: the power-on indication, the watchdog timeout and the clock-monitor failure. It also watches the sampled level of a shared, active-low, open-drain reset pin. When any of these becomes active, the block pulls the pin low for a fixed number of cycles and then lets go of it. A fixed number of cycles after the release it samples the pin once more. A pin that is still low means something outside the chip is holding reset, so the cause is external. A pin that has gone high means the cause was one of the internal sources.

The internal system reset stays asserted for the whole sequence. It is extended for as long as an external source holds the pin. It is also extended by the oscillator settling delay whenever a power-on event took part in the sequence. On leaving reset, the block marks a short window for fetching the restart vector. During that window it presents the vector address and gives a one-cycle pulse that tells the core to set its stop-disable and both interrupt-mask flags. Requests that arrive while a sequence is already running are folded into that sequence.

Top module: `rst_pin_seq`

## Requirements
- R1: While `rst` is high and afterwards until the first request, `sys_rst` is 1 and `pin_drive_low`, `vec_fetch` and `mask_set` are 0.
- R2: A request seen at a clock edge while idle (`por_req`, `wdog_req` or `cmon_req` high, or `pin_in` low) makes `pin_drive_low` 1 from the next cycle, for exactly PULSE_CYC (4) consecutive cycles, with `sys_rst` 1.
- R3: After the pin is released, `pin_in` is sampled in the SAMPLE_DLY-th (2nd) released cycle. A low sample marks the cause as external, and the vector becomes RST_VEC (16'hFFFE).
- R4: When the sample is high, the vector is chosen from the recorded internal causes in the order power-on, then clock monitor (CMON_VEC, 16'hFFFC), then watchdog (WDOG_VEC, 16'hFFFA). With none recorded, the vector is RST_VEC.
- R5: After an external sample, `sys_rst` stays 1 while `pin_in` is low. The fetch window starts in the cycle after the first edge at which `pin_in` is high.
- R6: When a power-on request took part in the sequence, `sys_rst` is held for a further POR_CYC (4064) cycles after the sample, or after the external hold ends, before the fetch window. The vector is RST_VEC.
- R7: On exit, `sys_rst` goes to 0 and `vec_fetch` is 1 for exactly FETCH_CYC (3) cycles. `vec_addr` holds the chosen vector and stays stable during the window. `mask_set` is 1 only in the first cycle of the window.
- R8: A request arriving during an active sequence does not restart or lengthen the pin pulse. It is merged into the cause set used for the vector, and into the power-on hold decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | E clock |
| rst | input | 1 | Synchronous active-high block reset |
| por_req | input | 1 | Power-on indication, oscillator running |
| wdog_req | input | 1 | Watchdog timeout request |
| cmon_req | input | 1 | Clock-monitor failure request |
| pin_in | input | 1 | Synchronised level of the reset pin (0 = low) |
| pin_drive_low | output | 1 | 1 = pull the reset pin low |
| sys_rst | output | 1 | Internal system reset, active high |
| vec_fetch | output | 1 | Restart-vector fetch window |
| vec_addr | output | VEC_W | Address of the selected restart vector |
| mask_set | output | 1 | One-cycle pulse: set stop-disable and both interrupt masks |

## Verification
Take the cycle right after the edge that accepts a request as cycle 0. The pin pulse then covers cycles 0 to 3, and the release cycles are 4 and 5. The fetch window opens at cycle 6 for a watchdog or clock-monitor cause. For an external hold released in cycle H, it opens at H+1. For a power-on cause it opens at 6+POR_CYC. The bench drives inputs and samples outputs on falling edges, and indexes every sampled cycle from that same origin. It records the first and last cycle of each output and compares them against these cycle numbers. The vector is captured in the first fetch cycle, and each merge scenario injects its second request at a known cycle index.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_WAIT,
    ST_HOLD,
    ST_POR,
    ST_FETCH
  } seq_state_t;

  localparam int NCAUSE     = 3;
  localparam int CAUSE_POR  = 0;
  localparam int CAUSE_WDOG = 1;
  localparam int CAUSE_CMON = 2;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/rps_step_cnt.sv
module rps_step_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rps_cause_latch.sv
module rps_cause_latch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] req,
  input  logic         ext_set,
  output logic [N-1:0] pend,
  output logic         ext
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr) pend[g] <= 1'b0;
      else            pend[g] <= pend[g] | req[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) ext <= 1'b0;
    else            ext <= ext | ext_set;
  end
endmodule

// File: rtl/rps_vector_sel.sv
module rps_vector_sel import rps_pkg::*; #(
  parameter int              VEC_W    = 16,
  parameter logic [VEC_W-1:0] RST_VEC  = 16'hFFFE,
  parameter logic [VEC_W-1:0] CMON_VEC = 16'hFFFC,
  parameter logic [VEC_W-1:0] WDOG_VEC = 16'hFFFA
) (
  input  logic [NCAUSE-1:0] cause,
  input  logic              ext,
  output logic [VEC_W-1:0]  vec
);
  always_comb begin
    if (cause[CAUSE_POR] || ext) vec = RST_VEC;
    else if (cause[CAUSE_CMON])  vec = CMON_VEC;
    else if (cause[CAUSE_WDOG])  vec = WDOG_VEC;
    else                         vec = RST_VEC;
  end
endmodule

// File: rtl/rst_pin_seq.sv
module rst_pin_seq import rps_pkg::*; #(
  parameter int               PULSE_CYC  = 4,
  parameter int               SAMPLE_DLY = 2,
  parameter int               POR_CYC    = 4064,
  parameter int               FETCH_CYC  = 3,
  parameter int               VEC_W      = 16,
  parameter logic [VEC_W-1:0] RST_VEC    = 16'hFFFE,
  parameter logic [VEC_W-1:0] CMON_VEC   = 16'hFFFC,
  parameter logic [VEC_W-1:0] WDOG_VEC   = 16'hFFFA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por_req,
  input  logic             wdog_req,
  input  logic             cmon_req,
  input  logic             pin_in,
  output logic             pin_drive_low,
  output logic             sys_rst,
  output logic             vec_fetch,
  output logic [VEC_W-1:0] vec_addr,
  output logic             mask_set
);
  localparam int LONGEST = max4(PULSE_CYC, SAMPLE_DLY, POR_CYC, FETCH_CYC);
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] PULSE_LAST  = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_DLY - 1);
  localparam logic [CNT_W-1:0] POR_LAST    = CNT_W'(POR_CYC - 1);
  localparam logic [CNT_W-1:0] FETCH_LAST  = CNT_W'(FETCH_CYC - 1);

  seq_state_t        state, state_n;
  logic [CNT_W-1:0]  cnt;
  logic [NCAUSE-1:0] req_v, pend, cur;
  logic              ext_cause, ext_set, enter_fetch;
  logic [VEC_W-1:0]  sel_vec;

  always_comb begin
    req_v = '0;
    req_v[CAUSE_POR]  = por_req;
    req_v[CAUSE_WDOG] = wdog_req;
    req_v[CAUSE_CMON] = cmon_req;
  end

  assign cur = pend | req_v;

  rps_step_cnt #(.W(CNT_W)) cnt_i (
    .clk (clk),
    .rst (rst),
    .clr (state_n != state),
    .cnt (cnt)
  );

  // Sample point: last released cycle before the decision.
  assign ext_set     = (state == ST_WAIT) && (cnt == SAMPLE_LAST) && !pin_in;
  assign enter_fetch = (state_n == ST_FETCH) && (state != ST_FETCH);

  rps_cause_latch #(.N(NCAUSE)) latch_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (enter_fetch),
    .req     (req_v),
    .ext_set (ext_set),
    .pend    (pend),
    .ext     (ext_cause)
  );

  rps_vector_sel #(
    .VEC_W(VEC_W), .RST_VEC(RST_VEC), .CMON_VEC(CMON_VEC), .WDOG_VEC(WDOG_VEC)
  ) vsel_i (
    .cause (cur),
    .ext   (ext_cause),
    .vec   (sel_vec)
  );

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:  if ((|cur) || !pin_in) state_n = ST_DRIVE;
      ST_DRIVE: if (cnt == PULSE_LAST) state_n = ST_WAIT;
      ST_WAIT:
        if (cnt == SAMPLE_LAST) begin
          if (!pin_in)                state_n = ST_HOLD;
          else if (cur[CAUSE_POR])    state_n = ST_POR;
          else                        state_n = ST_FETCH;
        end
      ST_HOLD:
        if (pin_in) state_n = cur[CAUSE_POR] ? ST_POR : ST_FETCH;
      ST_POR:   if (cnt == POR_LAST)   state_n = ST_FETCH;
      ST_FETCH: if (cnt == FETCH_LAST) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      pin_drive_low <= 1'b0;
      sys_rst       <= 1'b1;
      vec_fetch     <= 1'b0;
      mask_set      <= 1'b0;
      vec_addr      <= RST_VEC;
    end else begin
      state         <= state_n;
      pin_drive_low <= (state_n == ST_DRIVE);
      vec_fetch     <= (state_n == ST_FETCH);
      mask_set      <= enter_fetch;
      if (state_n == ST_DRIVE)      sys_rst <= 1'b1;
      else if (state_n == ST_FETCH) sys_rst <= 1'b0;
      if (enter_fetch) vec_addr <= sel_vec;
    end
  end
endmodule

// File: rtl/rst_pin_seq_chk.sv
module rst_pin_seq_chk #(
  parameter int               PULSE_CYC = 4,
  parameter int               VEC_W     = 16,
  parameter logic [VEC_W-1:0] RST_VEC   = 16'hFFFE,
  parameter logic [VEC_W-1:0] CMON_VEC  = 16'hFFFC,
  parameter logic [VEC_W-1:0] WDOG_VEC  = 16'hFFFA
) (
  input logic             clk,
  input logic             rst,
  input logic             pin_drive_low,
  input logic             sys_rst,
  input logic             vec_fetch,
  input logic [VEC_W-1:0] vec_addr,
  input logic             mask_set
);
  logic [15:0] drv_run;

  always_ff @(posedge clk) begin
    if (rst)                drv_run <= '0;
    else if (pin_drive_low) drv_run <= drv_run + 1'b1;
    else                    drv_run <= '0;
  end

  assert_drive_max_R2: assert property (@(posedge clk) disable iff (rst)
    drv_run <= 16'(PULSE_CYC));

  assert_drive_len_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(pin_drive_low) |-> (drv_run == 16'(PULSE_CYC)));

  assert_drive_in_reset_R2: assert property (@(posedge clk) disable iff (rst)
    pin_drive_low |-> sys_rst);

  assert_fetch_out_of_reset_R7: assert property (@(posedge clk) disable iff (rst)
    vec_fetch |-> (!sys_rst && !pin_drive_low));

  assert_mask_in_fetch_R7: assert property (@(posedge clk) disable iff (rst)
    mask_set |-> vec_fetch);

  assert_mask_first_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_fetch) |-> mask_set);

  assert_vec_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (vec_fetch && $past(vec_fetch)) |-> ($stable(vec_addr) && !mask_set));

  assert_vec_legal_R4: assert property (@(posedge clk) disable iff (rst)
    vec_fetch |-> (vec_addr == RST_VEC || vec_addr == CMON_VEC || vec_addr == WDOG_VEC));
endmodule

bind rst_pin_seq rst_pin_seq_chk #(
  .PULSE_CYC(PULSE_CYC), .VEC_W(VEC_W),
  .RST_VEC(RST_VEC), .CMON_VEC(CMON_VEC), .WDOG_VEC(WDOG_VEC)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .pin_drive_low (pin_drive_low),
  .sys_rst       (sys_rst),
  .vec_fetch     (vec_fetch),
  .vec_addr      (vec_addr),
  .mask_set      (mask_set)
);

// File: tb/rst_pin_seq_tb_top.sv
module rst_pin_seq_tb_top;
  localparam int POR_CYC = 4064;
  localparam int FIRST_FETCH = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por_req = 1'b0, wdog_req = 1'b0, cmon_req = 1'b0;
  logic ext_low = 1'b0;
  logic pin_in;
  logic pin_drive_low, sys_rst, vec_fetch, mask_set;
  logic [15:0] vec_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Open-drain pin model: low if the block or the outside pulls it.
  assign pin_in = ~(pin_drive_low | ext_low);

  always #10 clk = ~clk;

  rst_pin_seq dut_i (
    .clk(clk), .rst(rst), .por_req(por_req), .wdog_req(wdog_req), .cmon_req(cmon_req),
    .pin_in(pin_in), .pin_drive_low(pin_drive_low), .sys_rst(sys_rst),
    .vec_fetch(vec_fetch), .vec_addr(vec_addr), .mask_set(mask_set)
  );

  // Per-sequence record
  int n_drv, first_drv, first_fet, n_fet, n_mask, mask_idx, last_rst_hi;
  logic [15:0] vec_first;
  logic end_rst;

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Cycle 0 is the cycle after the edge that accepts the start request.
  task automatic run_seq(input int rel_at, input int inj_at, input logic [2:0] inj);
    n_drv = 0; first_drv = -1; first_fet = -1; n_fet = 0; n_mask = 0;
    mask_idx = -1; last_rst_hi = -1; vec_first = '0; end_rst = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (pin_drive_low) begin n_drv++; if (first_drv < 0) first_drv = i; end
      if (sys_rst) last_rst_hi = i;
      if (mask_set) begin n_mask++; mask_idx = i; end
      if (vec_fetch) begin
        n_fet++;
        if (first_fet < 0) begin first_fet = i; vec_first = vec_addr; end
      end
      if (i == 0 || i == inj_at + 1) begin por_req = 0; wdog_req = 0; cmon_req = 0; end
      if (i == inj_at) {cmon_req, wdog_req, por_req} = inj;
      if (i == rel_at) ext_low = 1'b0;
      if (first_fet >= 0 && !vec_fetch) begin end_rst = sys_rst; break; end
    end
  endtask

  task automatic check_exit(input string tag, input int exp_fet, input logic [15:0] exp_vec);
    chk(tag, "fetch start cycle", first_fet, exp_fet);
    chk(tag, "vector", vec_first, exp_vec);
    chk("R7", {tag, " last sys_rst high cycle"}, last_rst_hi, exp_fet - 1);
    chk("R7", {tag, " fetch length"}, n_fet, 3);
    chk("R7", {tag, " mask pulse count"}, n_mask, 1);
    chk("R7", {tag, " mask pulse cycle"}, mask_idx, exp_fet);
    chk("R7", {tag, " sys_rst after fetch"}, end_rst, 0);
  endtask

  task automatic check_pulse(input string tag);
    chk("R2", {tag, " pulse start"}, first_drv, 0);
    chk("R2", {tag, " pulse length"}, n_drv, 4);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1", "sys_rst in reset", sys_rst, 1);
    chk("R1", "pin drive in reset", pin_drive_low, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", "sys_rst idle after reset", sys_rst, 1);
    chk("R1", "pin drive idle", pin_drive_low, 0);
    chk("R1", "vec_fetch idle", vec_fetch, 0);
    chk("R1", "mask_set idle", mask_set, 0);
  endtask

  task automatic t_watchdog;
    @(negedge clk); wdog_req = 1'b1;
    run_seq(-1, -1, 3'b000);
    check_pulse("watchdog");
    check_exit("R4", FIRST_FETCH, 16'hFFFA);
  endtask

  task automatic t_clockmon;
    @(negedge clk); cmon_req = 1'b1;
    run_seq(-1, -1, 3'b000);
    check_pulse("clock monitor");
    check_exit("R4", FIRST_FETCH, 16'hFFFC);
  endtask

  task automatic t_both;
    @(negedge clk); cmon_req = 1'b1; wdog_req = 1'b1;
    run_seq(-1, -1, 3'b000);
    check_exit("R4", FIRST_FETCH, 16'hFFFC);
  endtask

  task automatic t_ext_hold;
    @(negedge clk); ext_low = 1'b1;
    run_seq(20, -1, 3'b000);
    check_pulse("external");
    check_exit("R5", 21, 16'hFFFE);
    chk("R3", "external vector", vec_first, 16'hFFFE);
  endtask

  task automatic t_ext_glitch;
    @(negedge clk); ext_low = 1'b1;
    run_seq(0, -1, 3'b000);
    check_pulse("glitch");
    check_exit("R3", FIRST_FETCH, 16'hFFFE);
  endtask

  task automatic t_merge_cmon;
    @(negedge clk); wdog_req = 1'b1;
    run_seq(-1, 2, 3'b100);
    check_pulse("merge");
    check_exit("R8", FIRST_FETCH, 16'hFFFC);
  endtask

  task automatic t_por;
    @(negedge clk); por_req = 1'b1;
    run_seq(-1, -1, 3'b000);
    check_pulse("power-on");
    check_exit("R6", FIRST_FETCH + POR_CYC, 16'hFFFE);
  endtask

  task automatic t_merge_por;
    @(negedge clk); wdog_req = 1'b1;
    run_seq(-1, 1, 3'b001);
    chk("R8", "merged power-on pulse length", n_drv, 4);
    check_exit("R6", FIRST_FETCH + POR_CYC, 16'hFFFE);
  endtask

  initial begin
    t_reset();
    t_watchdog();
    t_clockmon();
    t_both();
    t_ext_hold();
    t_ext_glitch();
    t_merge_cmon();
    t_por();
    t_merge_por();
    repeat (2) @(negedge clk);
    chk("R7", "idle after all sequences", sys_rst, 0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule